// File: doc/BRIEF.md
# Stack-Top Arithmetic Sequencer

This block is a zero-address integer unit. Operands are never named in an instruction. They are taken from an operand stack. The three shallowest stack cells are held in working registers, called first, second and third cell. Every deeper cell is kept in a small synchronous nesting memory, addressed by a depth pointer. Two adder-input registers and one buffer register hold operands between steps. A short control sequencer runs each instruction as a fixed series of one-clock steps.

For a binary operation, the first step copies the three top registers into the staging registers. In the same clock it launches the nesting-memory read for the cell that will refill the third position. The second step writes the adder result and moves the buffered third cell up. It also loads the word just read into the third position. The refill therefore costs no extra step. The exchange operation swaps the top pair of cells with the next pair. It keeps the displaced pair in the adder-input registers and writes the memory only in its final step.

Instructions arrive on a valid/ready port with a 3-bit opcode. A push word travels with the push opcode. The first and second cells and two sticky flags are visible for reading.

Top module: `nest_alu`

## Requirements
- R1: When synchronous reset is held, both visible cells read zero, the third cell and the depth pointer are cleared, `ovf_flag` and `stack_err` are low, `busy` is low and `in_ready` is high.
- R2: An instruction is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is always the inverse of `busy`. `busy` stays high for exactly 2 cycles after accepting add (1), subtract (2) or exchange (3), and for exactly 1 cycle after push (4), any other code, or a faulted instruction.
- R3: Add (opcode 1) replaces the stack's top two cells with their two's-complement sum modulo 2^DATA_W. The new second cell is the old third cell. The third cell is refilled from the nesting memory, and the depth drops by one.
- R4: Push (opcode 4) places `push_data` on top. The old first cell becomes the second, the old second becomes the third, and the old third is stored at the top of the nesting memory. The depth grows by one.
- R5: Subtract (opcode 2) behaves like add, except the result is the second cell minus the top cell. It is formed as the second cell plus the inverted top cell plus a carry-in of one.
- R6: `ovf_flag` is set after an add whose two operands share a sign that the sum does not have. It is also set after a subtract whose operands have different signs and whose result sign differs from the second cell's sign. Once set, it stays set until reset.
- R7: Exchange (opcode 3) leaves the order as: old third cell, old shallowest memory cell, old first cell, old second cell. The depth is unchanged.
- R8: Add, subtract or exchange issued while the nesting memory is empty sets sticky `stack_err`. So does push issued while it holds NEST_DEPTH cells. The faulted instruction changes no cell and no depth.
- R9: Opcodes 0, 5, 6 and 7 are accepted and change no cell or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to take an instruction |
| in_op | input | 3 | Opcode: 1 add, 2 subtract, 3 exchange, 4 push, others no-op |
| push_data | input | DATA_W | Word pushed by opcode 4 |
| busy | output | 1 | Instruction sequence in progress |
| top_w1 | output | DATA_W | First (top) stack cell |
| top_w2 | output | DATA_W | Second stack cell |
| ovf_flag | output | 1 | Sticky arithmetic overflow |
| stack_err | output | 1 | Sticky nesting-memory underflow or overflow |

## Verification
The embedded assertions check the step structure on every cycle. A second step always returns to idle. A push shifts the register cells down by one. An arithmetic pop lowers the depth pointer by exactly one, and an exchange leaves it unchanged. Both flags stay set once set, and the pointer never passes the memory depth.

Correct arithmetic values, the overflow sign rule and the exchange ordering can only be shown by the bench's scenarios. The same holds for the refill of the third cell from memory and for the no-change behaviour of faulted instructions and unused opcodes. The bench observes all of these at the visible cells after later pops.

// File: rtl/nest_pkg.sv
package nest_pkg;

    localparam int WORD_W = 48;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_XCHG = 3'd3,
        OP_PUSH = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2
    } step_e;

    typedef struct packed {
        op_e  op;
        logic fault;
    } instr_t;

    function automatic op_e decode_op(input logic [2:0] code);
        case (code)
            3'd1:    return OP_ADD;
            3'd2:    return OP_SUB;
            3'd3:    return OP_XCHG;
            3'd4:    return OP_PUSH;
            default: return OP_NOP;
        endcase
    endfunction

    function automatic logic is_arith(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic is_two_step(input op_e op);
        return is_arith(op) || (op == OP_XCHG);
    endfunction

endpackage

// File: rtl/nest_ram.sv
module nest_ram #(
    parameter int DATA_W = 48,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    // read-first synchronous port
    always_ff @(posedge clk) begin
        rdata <= cells[addr];
        if (we) begin
            cells[addr] <= wdata;
        end
    end
endmodule

// File: rtl/nest_adder.sv
module nest_adder #(
    parameter int DATA_W = 48
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              ovf
);
    logic [DATA_W-1:0] opnd;

    always_comb begin
        opnd = sub ? ~b : b;
        sum  = a + opnd + DATA_W'(cin);
        // operands agree in sign but the result does not
        ovf  = (a[DATA_W-1] == opnd[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);
    end
endmodule

// File: rtl/nest_seq.sv
module nest_seq
    import nest_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  accept,
    input  op_e   op_in,
    output step_e step,
    output op_e   op_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step <= ST_IDLE;
            op_q <= OP_NOP;
        end else begin
            case (step)
                ST_IDLE: if (accept) begin
                    step <= ST_ONE;
                    op_q <= op_in;
                end
                ST_ONE:  step <= is_two_step(op_q) ? ST_TWO : ST_IDLE;
                default: step <= ST_IDLE;
            endcase
        end
    end

    a_r2_two_then_idle: assert property (@(posedge clk) disable iff (rst)
        (step == ST_TWO) |=> (step == ST_IDLE));
    a_r2_accept_steps: assert property (@(posedge clk) disable iff (rst)
        (accept && step == ST_IDLE) |=> (step == ST_ONE));
    a_r2_one_step_ops: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ONE && !is_two_step(op_q)) |=> (step == ST_IDLE));
endmodule

// File: rtl/nest_alu.sv
module nest_alu
    import nest_pkg::*;
#(
    parameter int DATA_W     = nest_pkg::WORD_W,
    parameter int NEST_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_op,
    input  logic [DATA_W-1:0] push_data,
    output logic              busy,
    output logic [DATA_W-1:0] top_w1,
    output logic [DATA_W-1:0] top_w2,
    output logic              ovf_flag,
    output logic              stack_err
);
    localparam int AW = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;
    localparam int PW = $clog2(NEST_DEPTH + 1);
    localparam logic [PW-1:0] FULL = PW'(NEST_DEPTH);

    step_e step;
    op_e   op_q;
    logic  accept;
    instr_t dec;

    logic [DATA_W-1:0] w1, w2, w3, b1, b2, nb;
    logic              cin_q;
    logic [PW-1:0]     ptr, ptr_m1;
    logic              ovf_q, err_q;

    logic              ram_we;
    logic [AW-1:0]     ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;
    logic [DATA_W-1:0] sum;
    logic              sum_ovf;

    assign busy     = (step != ST_IDLE);
    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;
    assign ptr_m1   = ptr - PW'(1);

    always_comb begin
        dec.op    = decode_op(in_op);
        dec.fault = ((is_two_step(dec.op)) && (ptr == '0)) ||
                    ((dec.op == OP_PUSH) && (ptr == FULL));
    end

    nest_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .op_in  (dec.fault ? OP_NOP : dec.op),
        .step   (step),
        .op_q   (op_q)
    );

    nest_adder #(.DATA_W(DATA_W)) u_add (
        .a   (b1),
        .b   (b2),
        .sub (op_q == OP_SUB),
        .cin (cin_q),
        .sum (sum),
        .ovf (sum_ovf)
    );

    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = ptr_m1[AW-1:0];
        ram_wdata = w3;
        if (step == ST_ONE && op_q == OP_PUSH) begin
            ram_we   = 1'b1;
            ram_addr = ptr[AW-1:0];
        end else if (step == ST_TWO && op_q == OP_XCHG) begin
            ram_we    = 1'b1;
            ram_wdata = b1;
        end
    end

    nest_ram #(.DATA_W(DATA_W), .DEPTH(NEST_DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            w1    <= '0;
            w2    <= '0;
            w3    <= '0;
            b1    <= '0;
            b2    <= '0;
            nb    <= '0;
            cin_q <= 1'b0;
            ptr   <= '0;
            ovf_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            case (step)
                ST_IDLE: if (accept) begin
                    nb <= push_data;
                    if (dec.fault) err_q <= 1'b1;
                end
                ST_ONE: begin
                    if (is_arith(op_q)) begin
                        b2    <= w1;
                        b1    <= w2;
                        nb    <= w3;
                        cin_q <= (op_q == OP_SUB);
                        ptr   <= ptr_m1;
                    end else if (op_q == OP_XCHG) begin
                        b2 <= w1;
                        b1 <= w2;
                    end else if (op_q == OP_PUSH) begin
                        w1  <= nb;
                        w2  <= w1;
                        w3  <= w2;
                        ptr <= ptr + PW'(1);
                    end
                end
                ST_TWO: begin
                    if (is_arith(op_q)) begin
                        w1 <= sum;
                        w2 <= nb;
                        w3 <= ram_rdata;
                        if (sum_ovf) ovf_q <= 1'b1;
                    end else if (op_q == OP_XCHG) begin
                        w1 <= w3;
                        w2 <= ram_rdata;
                        w3 <= b2;
                    end
                end
                default: ;
            endcase
        end
    end

    assign top_w1    = w1;
    assign top_w2    = w2;
    assign ovf_flag  = ovf_q;
    assign stack_err = err_q;

    a_r3_pop_depth: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ONE && is_arith(op_q)) |=> (ptr == $past(ptr) - PW'(1)));
    a_r4_push_shift: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ONE && op_q == OP_PUSH) |=> (w2 == $past(w1) && w3 == $past(w2)));
    a_r7_xchg_depth: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ONE && op_q == OP_XCHG) |=> ##1 (ptr == $past(ptr, 2)));
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= FULL);
endmodule

// File: tb/test_nest_alu.sv
module test_nest_alu;
    localparam int W = 48;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_op = '0;
    logic [W-1:0] push_data = '0;
    logic         busy;
    logic [W-1:0] top_w1, top_w2;
    logic         ovf_flag, stack_err;

    nest_alu #(.DATA_W(W), .NEST_DEPTH(D)) i_nest_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .push_data(push_data), .busy(busy),
        .top_w1(top_w1), .top_w2(top_w2), .ovf_flag(ovf_flag), .stack_err(stack_err)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [W-1:0] m [0:10];
    int  cnt;
    bit  movf, merr;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i <= 10; i++) m[i] = '0;
        cnt = 0; movf = 0; merr = 0;
    endtask

    // returns expected busy length
    function automatic int model_apply(input logic [2:0] op, input logic [W-1:0] d);
        logic [W-1:0] a, b, r, t;
        bit o;
        case (op)
            3'd1, 3'd2: begin
                if (cnt == 0) begin merr = 1; return 1; end
                a = m[1]; b = m[0];
                if (op == 3'd1) begin
                    r = a + b;
                    o = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
                end else begin
                    r = a - b;
                    o = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
                end
                if (o) movf = 1;
                m[0] = r;
                for (int i = 1; i < 10; i++) m[i] = m[i+1];
                cnt--;
                return 2;
            end
            3'd3: begin
                if (cnt == 0) begin merr = 1; return 1; end
                t = m[0]; m[0] = m[2]; m[2] = t;
                t = m[1]; m[1] = m[3]; m[3] = t;
                return 2;
            end
            3'd4: begin
                if (cnt == D) begin merr = 1; return 1; end
                for (int i = 10; i > 0; i--) m[i] = m[i-1];
                m[0] = d;
                cnt++;
                return 1;
            end
            default: return 1;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic do_op(input string tag, input logic [2:0] op, input logic [W-1:0] d);
        int exp_len, n;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_op = op; push_data = d;
        exp_len = model_apply(op, d);
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (busy) begin
            if (in_ready) chk({tag, " R2 ready while busy"}, 64'(in_ready), 64'(0));
            n++;
            @(negedge clk);
        end
        chk({tag, " R2 busy length"}, 64'(n), 64'(exp_len));
        chk({tag, " W1"}, 64'(top_w1), 64'(m[0]));
        chk({tag, " W2"}, 64'(top_w2), 64'(m[1]));
        chk({tag, " R6 ovf"}, 64'(ovf_flag), 64'(movf));
        chk({tag, " R8 err"}, 64'(stack_err), 64'(merr));
    endtask

    logic [W-1:0] vals [0:7];

    initial begin
        vals[0] = 48'h0;             vals[1] = 48'h1;
        vals[2] = 48'hFFFF_FFFF_FFFF; vals[3] = 48'h7FFF_FFFF_FFFF;
        vals[4] = 48'h8000_0000_0000; vals[5] = 48'h1234_5678_9ABC;
        vals[6] = 48'h8000_0000_0001; vals[7] = 48'h7FFF_FFFF_0000;

        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 W1", 64'(top_w1), 64'(0));
        chk("R1 W2", 64'(top_w2), 64'(0));
        chk("R1 flags", 64'({ovf_flag, stack_err, busy}), 64'(0));
        chk("R1 ready", 64'(in_ready), 64'(1));
        rst = 1'b0;

        // R3 R5 R6 sweep over add and subtract
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int s = 1; s <= 2; s++) begin
                    do_reset();
                    do_op("R4 push", 3'd4, vals[i]);
                    do_op("R4 push", 3'd4, vals[j]);
                    do_op(s == 1 ? "R3 add" : "R5 sub", 3'(s), '0);
                end
            end
        end

        // R7 exchange then reveal deeper cells with pops (refill R3)
        do_reset();
        for (int k = 1; k <= 5; k++) do_op("R4 push", 3'd4, 48'(k * 48'h1111_0000_0101));
        do_op("R7 xchg", 3'd3, '0);
        do_op("R3 refill add", 3'd1, '0);
        do_op("R3 refill add", 3'd1, '0);
        do_op("R5 refill sub", 3'd2, '0);

        // R9 unused codes leave state alone
        do_reset();
        do_op("R4 push", 3'd4, 48'hABCD);
        do_op("R4 push", 3'd4, 48'h1357);
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 5) do_op("R9 noop", 3'(c), 48'hDEAD);
        end
        do_op("R9 after noop add", 3'd1, '0);

        // R8 faults: empty pop, empty exchange, full push
        do_reset();
        do_op("R8 empty add", 3'd1, '0);
        do_reset();
        do_op("R8 empty xchg", 3'd3, '0);
        do_op("R8 empty sub", 3'd2, '0);
        do_reset();
        for (int k = 0; k < D + 1; k++) do_op("R8 fill", 3'd4, 48'(k + 100));
        do_op("R8 full push", 3'd4, 48'h5555);
        for (int k = 0; k < D; k++) do_op("R8 drain", 3'd1, '0);
        do_op("R8 underflow after drain", 3'd2, '0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule